// File: doc/BRIEF.md
# Serial control command decoder

This block sits behind a byte-oriented serial control port. Each transfer is a frame: the frame input is held high, bytes arrive one per valid cycle, and the frame ends when the frame input drops. The first byte of a frame is a command. That byte alone decides whether a two-byte address follows, how many bytes make one data word (1, 2, 3 or 5), which storage area is written, and how many words the frame may write.

After the header, the decoder packs data bytes most significant byte first. For each complete word it gives a one-cycle write strobe with area, address and right-aligned data. For RAM-like areas the address steps up by one per word. Staged run-time commands carry a word cap, and words past that cap are dropped without a strobe. Commit commands give a commit pulse instead of writes. Commands that are only allowed in system reset, and unknown codes, raise an error pulse and make the decoder ignore the rest of the frame.

Area codes on `wr_area_o`: 0 control register, 1 coefficient RAM, 2 offset register, 3 program RAM, 4 accumulator-coefficient RAM, 5 CRC, 6 jump code.

Top module: `ctl_cmd_decoder`

## Requirements
- R1: While reset is high and in the cycle after it, `wr_en_o`, `commit_o` and `err_o` are low.
- R2: Commands 0x80–0x8F write area 1 and commands 0x90–0x9F write area 2. Each has a 16-bit address (high byte first) and 3-byte words.
- R3: For 0x8X and 0x9X, at most X+1 words are written. Later words in the same frame give no strobe.
- R4: Each further complete word in a frame is written to the previous word's address plus one.
- R5: 0xA2 (area 2) and 0xA4 (area 1) take two address bytes. After the second address byte they pulse `commit_o` for one cycle, with that address and area, and they never strobe a write.
- R6: With `run_mode_i` low, 0xB2 writes area 2, 0xB4 writes area 1 and 0xBB writes area 4, each with 3-byte words. 0xB8 writes area 3 with 5-byte words. All have an address and no word cap.
- R7: A 0xBX command received while `run_mode_i` is high pulses `err_o` in the cycle after the command byte. The rest of the frame gives no write or commit.
- R8: Commands 0xC0–0xDF write control register (cmd & 0x1F), 0xE6 writes register 0x26 and 0xEA writes register 0x2A. Each takes one 1-byte word, has no address bytes, and uses the register number as `wr_addr_o`, in area 0. Further bytes are ignored.
- R9: 0xF2 writes one 2-byte word to area 5 and 0xF4 writes one 1-byte word to area 6, both at address 0 with no address bytes.
- R10: Any command code not listed in R2–R9 pulses `err_o` and the rest of the frame is ignored.
- R11: A word left incomplete when the frame drops is not written. The next frame is decoded from its first byte as a fresh command.
- R12: `wr_en_o` is high for exactly the one cycle after the clock edge that accepts a word's last byte. Cycles with `byte_valid_i` low accept nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | High for the duration of a frame |
| byte_valid_i | input | 1 | A byte is presented this cycle |
| byte_i | input | 8 | Received byte |
| run_mode_i | input | 1 | 1 = running, 0 = system reset mode |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_area_o | output | 3 | Target area code |
| wr_addr_o | output | ADDR_W | Word address |
| wr_data_o | output | DATA_W | Right-aligned word data |
| commit_o | output | 1 | One-cycle commit pulse for staged writes |
| err_o | output | 1 | One-cycle rejected-command pulse |

## Verification
The assertions assume that `byte_valid_i` is raised only while `frame_i` is high, and that `run_mode_i` does not change inside a frame. Both are inputs the serial shifter and system control provide. The stimulus changes the run mode only between frames, with the frame low. It raises byte-valid only after raising the frame and drops it no later than the frame. Under these conditions the checker can tie every strobe to an accepted byte inside a live frame.

// File: rtl/ctl_cmd_pkg.sv
package ctl_cmd_pkg;
  parameter int unsigned BYTE_W    = 8;
  parameter int unsigned MAX_STAGE = 16;
  parameter int unsigned CAP_W     = $clog2(MAX_STAGE + 1);
  parameter int unsigned LEN_W     = 3;

  typedef enum logic [2:0] {
    AR_CTRL = 3'd0,
    AR_COEF = 3'd1,
    AR_OFST = 3'd2,
    AR_PROG = 3'd3,
    AR_ACCO = 3'd4,
    AR_CRC  = 3'd5,
    AR_JUMP = 3'd6
  } area_e;

  typedef struct packed {
    logic              known;
    logic              has_addr;
    logic              reset_only;
    logic              commit;
    logic              capped;
    logic [CAP_W-1:0]  cap;
    logic [LEN_W-1:0]  nbytes;
    area_e             area;
    logic [BYTE_W-1:0] reg_addr;
  } cmd_info_t;
endpackage

// File: rtl/ctl_cmd_lut.sv
module ctl_cmd_lut
  import ctl_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  output cmd_info_t         info_o
);
  always_comb begin
    info_o = '0;
    info_o.area = AR_CTRL;
    casez (cmd_i)
      8'b1000_????, 8'b1001_????: begin
        info_o.known    = 1'b1;
        info_o.has_addr = 1'b1;
        info_o.capped   = 1'b1;
        info_o.cap      = CAP_W'(cmd_i[3:0]) + 1'b1;
        info_o.nbytes   = LEN_W'(3);
        info_o.area     = cmd_i[4] ? AR_OFST : AR_COEF;
      end
      8'hA2, 8'hA4: begin
        info_o.known    = 1'b1;
        info_o.has_addr = 1'b1;
        info_o.commit   = 1'b1;
        info_o.capped   = 1'b1;
        info_o.nbytes   = LEN_W'(3);
        info_o.area     = cmd_i[2] ? AR_COEF : AR_OFST;
      end
      8'hB2, 8'hB4, 8'hBB, 8'hB8: begin
        info_o.known      = 1'b1;
        info_o.has_addr   = 1'b1;
        info_o.reset_only = 1'b1;
        info_o.nbytes     = (cmd_i == 8'hB8) ? LEN_W'(5) : LEN_W'(3);
        case (cmd_i)
          8'hB2:   info_o.area = AR_OFST;
          8'hB4:   info_o.area = AR_COEF;
          8'hBB:   info_o.area = AR_ACCO;
          default: info_o.area = AR_PROG;
        endcase
      end
      8'b110?_????, 8'hE6, 8'hEA: begin
        info_o.known    = 1'b1;
        info_o.capped   = 1'b1;
        info_o.cap      = CAP_W'(1);
        info_o.nbytes   = LEN_W'(1);
        info_o.area     = AR_CTRL;
        if (cmd_i == 8'hE6)      info_o.reg_addr = 8'h26;
        else if (cmd_i == 8'hEA) info_o.reg_addr = 8'h2A;
        else                     info_o.reg_addr = {3'b000, cmd_i[4:0]};
      end
      8'hF2, 8'hF4: begin
        info_o.known  = 1'b1;
        info_o.capped = 1'b1;
        info_o.cap    = CAP_W'(1);
        info_o.nbytes = (cmd_i == 8'hF2) ? LEN_W'(2) : LEN_W'(1);
        info_o.area   = (cmd_i == 8'hF2) ? AR_CRC : AR_JUMP;
      end
      default: info_o.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctl_word_packer.sv
module ctl_word_packer #(
  parameter int DATA_W = 40,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              push,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [LEN_W-1:0]  word_len,
  output logic              done,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] acc_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  idx_nx;

  assign idx_nx = idx_q + 1'b1;
  assign done   = push && (idx_nx == word_len);
  assign word   = {acc_q[DATA_W-BYTE_W-1:0], byte_in};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (push) begin
      if (done) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q <= word;
        idx_q <= idx_nx;
      end
    end
  end
endmodule

// File: rtl/ctl_burst_tracker.sv
module ctl_burst_tracker #(
  parameter int ADDR_W = 16,
  parameter int CAP_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              cap_en,
  input  logic [CAP_W-1:0]  cap,
  input  logic              word_done,
  output logic              allow,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [CAP_W-1:0]  cnt_q;
  logic [CAP_W-1:0]  cap_q;
  logic              cap_en_q;

  assign allow    = !cap_en_q || (cnt_q < cap_q);
  assign cur_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      cap_q    <= '0;
      cap_en_q <= 1'b0;
    end else if (load) begin
      addr_q   <= load_addr;
      cnt_q    <= '0;
      cap_q    <= cap;
      cap_en_q <= cap_en;
    end else if (word_done && allow) begin
      addr_q <= addr_q + 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_cmd_decoder.sv
module ctl_cmd_decoder
  import ctl_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              run_mode_i,
  output logic              wr_en_o,
  output logic [2:0]        wr_area_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              err_o
);
  typedef enum logic [2:0] {S_CMD, S_AHI, S_ALO, S_DATA, S_DROP} st_e;

  st_e               st_q;
  cmd_info_t         info_in, info_q;
  logic [BYTE_W-1:0] ahi_q;
  logic              take, reject;
  logic              pk_done, allow;
  logic [DATA_W-1:0] pk_word;
  logic [ADDR_W-1:0] cur_addr, ld_addr, full_addr;
  logic              ld, ld_cap_en;
  logic [CAP_W-1:0]  ld_cap;

  assign take      = frame_i && byte_valid_i;
  assign full_addr = ADDR_W'({ahi_q, byte_i});

  ctl_cmd_lut u_lut (
    .cmd_i  (byte_i),
    .info_o (info_in)
  );

  assign reject = !info_in.known || (info_in.reset_only && run_mode_i);

  always_comb begin
    ld        = 1'b0;
    ld_addr   = full_addr;
    ld_cap_en = info_q.capped;
    ld_cap    = info_q.cap;
    if (take && st_q == S_CMD && !reject && !info_in.has_addr) begin
      ld        = 1'b1;
      ld_addr   = ADDR_W'(info_in.reg_addr);
      ld_cap_en = info_in.capped;
      ld_cap    = info_in.cap;
    end else if (take && st_q == S_ALO && !info_q.commit) begin
      ld = 1'b1;
    end
  end

  ctl_word_packer #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .LEN_W  (LEN_W)
  ) u_pack (
    .clk      (clk),
    .rst      (rst),
    .clear    (!frame_i || st_q != S_DATA),
    .push     (take && st_q == S_DATA),
    .byte_in  (byte_i),
    .word_len (info_q.nbytes),
    .done     (pk_done),
    .word     (pk_word)
  );

  ctl_burst_tracker #(
    .ADDR_W (ADDR_W),
    .CAP_W  (CAP_W)
  ) u_burst (
    .clk       (clk),
    .rst       (rst),
    .load      (ld),
    .load_addr (ld_addr),
    .cap_en    (ld_cap_en),
    .cap       (ld_cap),
    .word_done (pk_done),
    .allow     (allow),
    .cur_addr  (cur_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_CMD;
      info_q <= '0;
      ahi_q  <= '0;
    end else if (!frame_i) begin
      st_q <= S_CMD;
    end else if (take) begin
      case (st_q)
        S_CMD: begin
          info_q <= info_in;
          if (reject)                st_q <= S_DROP;
          else if (info_in.has_addr) st_q <= S_AHI;
          else                       st_q <= S_DATA;
        end
        S_AHI: begin
          ahi_q <= byte_i;
          st_q  <= S_ALO;
        end
        S_ALO:   st_q <= info_q.commit ? S_DROP : S_DATA;
        default: st_q <= st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      commit_o  <= 1'b0;
      err_o     <= 1'b0;
      wr_area_o <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o  <= pk_done && allow;
      commit_o <= take && st_q == S_ALO && info_q.commit;
      err_o    <= take && st_q == S_CMD && reject;
      if (pk_done && allow) begin
        wr_area_o <= info_q.area;
        wr_addr_o <= cur_addr;
        wr_data_o <= pk_word;
      end else if (take && st_q == S_ALO && info_q.commit) begin
        wr_area_o <= info_q.area;
        wr_addr_o <= full_addr;
      end
    end
  end
endmodule

// File: rtl/ctl_cmd_decoder_chk.sv
module ctl_cmd_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_i,
  input logic              byte_valid_i,
  input logic              wr_en_o,
  input logic [2:0]        wr_area_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              commit_o,
  input logic              err_o
);
  a_r12_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
    byte_valid_i |-> frame_i);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  a_r12_strobe_from_byte: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(frame_i && byte_valid_i));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!wr_en_o && !commit_o));

  a_r5_commit_no_write: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> !wr_en_o);

  a_r8_ctrl_byte_wide: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_area_o == 3'd0) |-> (wr_data_o[DATA_W-1:8] == '0 && wr_addr_o[ADDR_W-1:8] == '0));

  a_r9_crc_width: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_area_o == 3'd5) |-> (wr_data_o[DATA_W-1:16] == '0 && wr_addr_o == '0));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!wr_en_o && !commit_o && !err_o));
endmodule

bind ctl_cmd_decoder ctl_cmd_decoder_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_i      (frame_i),
  .byte_valid_i (byte_valid_i),
  .wr_en_o      (wr_en_o),
  .wr_area_o    (wr_area_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .commit_o     (commit_o),
  .err_o        (err_o)
);

// File: tb/test_ctl_cmd_decoder.sv
module test_ctl_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame = 1'b0;
  logic        bv = 1'b0;
  logic [7:0]  bytev = 8'h00;
  logic        run = 1'b1;
  logic        wr_en_o, commit_o, err_o;
  logic [2:0]  wr_area_o;
  logic [15:0] wr_addr_o;
  logic [39:0] wr_data_o;

  int checks = 0;
  int errors = 0;
  int nwr = 0;
  int ncommit = 0;
  int nerr = 0;
  bit finished = 0;
  logic [7:0] pat = 8'h3C;

  // reference model state
  logic [7:0] fq[$];
  bit         dead = 0;
  bit         e_wr = 0, e_commit = 0, e_err = 0;
  logic [2:0] e_area = 0;
  logic [15:0] e_addr = 0;
  logic [39:0] e_data = 0;
  string      tag = "R12";

  always #10 clk = ~clk;

  ctl_cmd_decoder i_ctl_cmd_decoder (
    .clk          (clk),
    .rst          (rst),
    .frame_i      (frame),
    .byte_valid_i (bv),
    .byte_i       (bytev),
    .run_mode_i   (run),
    .wr_en_o      (wr_en_o),
    .wr_area_o    (wr_area_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .commit_o     (commit_o),
    .err_o        (err_o)
  );

  task automatic decode(input logic [7:0] c, output bit ok, output bit ha, output int nb,
                        output int maxw, output int ar, output int base, output bit ro,
                        output bit cm, output string rt);
    ok = 1; ha = 0; nb = 1; maxw = 1; ar = 0; base = 0; ro = 0; cm = 0; rt = "R12";
    if (c[7:5] == 3'b100) begin
      ha = 1; nb = 3; maxw = int'(c[3:0]) + 1; ar = c[4] ? 2 : 1; rt = "R2";
    end else if (c == 8'hA2 || c == 8'hA4) begin
      ha = 1; cm = 1; maxw = 0; ar = (c == 8'hA4) ? 1 : 2; rt = "R5";
    end else if (c == 8'hB2 || c == 8'hB4 || c == 8'hBB || c == 8'hB8) begin
      ha = 1; ro = 1; maxw = -1; rt = "R6";
      nb = (c == 8'hB8) ? 5 : 3;
      ar = (c == 8'hB2) ? 2 : (c == 8'hB4) ? 1 : (c == 8'hBB) ? 4 : 3;
    end else if (c[7:5] == 3'b110) begin
      base = int'(c[4:0]); rt = "R8";
    end else if (c == 8'hE6) begin
      base = 'h26; rt = "R8";
    end else if (c == 8'hEA) begin
      base = 'h2A; rt = "R8";
    end else if (c == 8'hF2) begin
      nb = 2; ar = 5; rt = "R9";
    end else if (c == 8'hF4) begin
      ar = 6; rt = "R9";
    end else begin
      ok = 0;
    end
  endtask

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    bit ok, ha, ro, cm;
    int nb, maxw, ar, base, n, hdr, d, w;
    string rt;
    e_wr = 0; e_commit = 0; e_err = 0; tag = "R12";
    if (rst || !frame) begin
      fq.delete();
      dead = 0;
      if (!rst) tag = "R11";
    end else if (bv) begin
      fq.push_back(bytev);
      n = fq.size();
      decode(fq[0], ok, ha, nb, maxw, ar, base, ro, cm, rt);
      if (n == 1) begin
        if (!ok || (ro && run)) begin
          e_err = 1; dead = 1; tag = ok ? "R7" : "R10";
        end
      end else if (dead) begin
        tag = (fq[0][7:4] == 4'hB) ? "R7" : "R10";
      end else begin
        hdr = ha ? 3 : 1;
        if (cm) begin
          tag = "R5";
          if (n == 3) begin
            e_commit = 1; e_area = 3'(ar); e_addr = {fq[1], fq[2]};
          end
        end else if (n > hdr) begin
          d = n - hdr;
          tag = rt;
          if (d % nb == 0) begin
            w = d / nb - 1;
            if (maxw < 0 || w < maxw) begin
              e_wr = 1; e_area = 3'(ar);
              e_addr = (ha ? {fq[1], fq[2]} : 16'(base)) + 16'(w);
              e_data = '0;
              for (int i = 0; i < nb; i++) e_data = {e_data[31:0], fq[hdr + w*nb + i]};
              if (w > 0) tag = "R4";
            end else begin
              tag = "R3";
            end
          end
        end
      end
    end
  end

  task automatic chk(input string t, input string what, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  // compare with the model away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(tag, "wr_en", 40'(wr_en_o), 40'(e_wr));
      chk(tag, "commit", 40'(commit_o), 40'(e_commit));
      chk(tag, "err", 40'(err_o), 40'(e_err));
      if (e_wr || e_commit) begin
        chk(tag, "area", 40'(wr_area_o), 40'(e_area));
        chk(tag, "addr", 40'(wr_addr_o), 40'(e_addr));
      end
      if (e_wr) chk(tag, "data", wr_data_o, e_data);
      if (wr_en_o) nwr++;
      if (commit_o) ncommit++;
      if (err_o) nerr++;
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    frame = 1'b1; bv = 1'b1; bytev = b;
  endtask

  task automatic gap();
    @(negedge clk);
    bv = 1'b0; bytev = 8'hEE;
  endtask

  task automatic start(input logic [7:0] c, input bit run_mode);
    @(negedge clk);
    run = run_mode;
    nwr = 0; ncommit = 0; nerr = 0;
    put(c);
  endtask

  task automatic endf();
    @(negedge clk);
    bv = 1'b0; frame = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic data(input int count);
    for (int i = 0; i < count; i++) begin
      pat = pat * 8'd13 + 8'd7;
      put(pat);
    end
  endtask

  task automatic expect_counts(input string t, input int w, input int c, input int e);
    chk(t, "write count", 40'(nwr), 40'(w));
    chk(t, "commit count", 40'(ncommit), 40'(c));
    chk(t, "error count", 40'(nerr), 40'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "wr_en in reset", 40'(wr_en_o), 40'd0);
    chk("R1", "commit in reset", 40'(commit_o), 40'd0);
    chk("R1", "err in reset", 40'(err_o), 40'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "wr_en after reset", 40'(wr_en_o), 40'd0);

    // R2 R3: staged coefficient writes capped at 3 words
    start(8'h82, 1); put(8'h00); put(8'h10); data(12); endf();
    expect_counts("R3", 3, 0, 0);
    // R2 R4: offset area, full 16-word cap then overflow
    start(8'h9F, 1); put(8'h01); put(8'hFE); data(17*3); endf();
    expect_counts("R3", 16, 0, 0);
    start(8'h90, 1); put(8'h00); put(8'h00); data(6); endf();
    expect_counts("R3", 1, 0, 0);
    // R5: commits
    start(8'hA4, 1); put(8'h00); put(8'h00); data(3); endf();
    expect_counts("R5", 0, 1, 0);
    start(8'hA2, 1); put(8'h00); put(8'h00); endf();
    expect_counts("R5", 0, 1, 0);
    // R7: reset-only command while running
    start(8'hB4, 1); put(8'h00); put(8'h20); data(6); endf();
    expect_counts("R7", 0, 0, 1);
    start(8'hB8, 1); put(8'h00); put(8'h00); data(5); endf();
    expect_counts("R7", 0, 0, 1);
    // R6: system reset mode writes, no cap, gaps between bytes (R12)
    start(8'hB4, 0); put(8'h02); put(8'h00); data(18*3); endf();
    expect_counts("R6", 18, 0, 0);
    start(8'hB8, 0); put(8'h00); put(8'h40);
    for (int i = 0; i < 10; i++) begin data(1); gap(); end
    endf();
    expect_counts("R12", 2, 0, 0);
    start(8'hBB, 0); put(8'h00); put(8'h07); data(3); endf();
    expect_counts("R6", 1, 0, 0);
    start(8'hB2, 0); put(8'hFF); put(8'hFF); data(6); endf();
    expect_counts("R4", 2, 0, 0);
    start(8'h85, 0); put(8'h00); put(8'h30); data(6); endf();
    expect_counts("R2", 2, 0, 0);
    // R8: control registers
    start(8'hC5, 1); data(4); endf();
    expect_counts("R8", 1, 0, 0);
    start(8'hDF, 1); data(1); endf();
    start(8'hC0, 0); data(1); endf();
    start(8'hE6, 1); data(2); endf();
    expect_counts("R8", 1, 0, 0);
    start(8'hEA, 1); data(1); endf();
    // R9: CRC and jump code
    start(8'hF2, 1); data(4); endf();
    expect_counts("R9", 1, 0, 0);
    start(8'hF4, 0); data(1); endf();
    expect_counts("R9", 1, 0, 0);
    // R10: unknown codes
    start(8'h00, 1); data(4); endf();
    expect_counts("R10", 0, 0, 1);
    start(8'hA0, 0); data(4); endf();
    start(8'hE0, 1); data(2); endf();
    start(8'hFF, 0); data(3); endf();
    expect_counts("R10", 0, 0, 1);
    start(8'hB0, 0); data(3); endf();
    expect_counts("R10", 0, 0, 1);
    // R11: partial word dropped, next frame clean
    start(8'hB4, 0); put(8'h00); put(8'h50); data(5); endf();
    expect_counts("R11", 1, 0, 0);
    start(8'hB8, 0); put(8'h00); data(1); endf();
    expect_counts("R11", 0, 0, 0);
    start(8'hC3, 1); data(1); endf();
    expect_counts("R11", 1, 0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule